// File: doc/BRIEF.md
# Shared-Bus Arbiter with Selectable Fixed or Aging Priority

This block chooses which of four bus masters owns a shared bus in a given cycle. Each master drives a request line. The arbiter returns a grant vector in which at most one bit is set. The grant follows the requests combinationally in the same cycle, so a master can see its grant in the cycle it asks. The data multiplexing and the slave side of the bus sit outside this block.

A policy input selects one of two arbitration rules. Under the static rule, the lowest-numbered requester always wins. Under the aging rule, each master has a small saturating counter. The requester with the largest counter wins. After every cycle with a grant, the winner's counter drops to zero and every other counter climbs by one. A master that waits therefore gains standing until it is served.

Top module: `dual_policy_arbiter`

## Requirements
- R1: `gnt_o` has at most one bit set. A bit is set only for a master whose `req_i` bit is set. Whenever `req_i` is nonzero, exactly one grant bit is set.
- R2: With `mode_i`=0 (static), the grant goes to the requesting master with the lowest index, so master 0 beats all others.
- R3: With `mode_i`=1 (aging), the grant goes to the requesting master whose age counter holds the largest value.
- R4: In aging mode, when several requesters share the largest counter value, the one with the lowest index wins.
- R5: In aging mode, in the cycle after a grant, the granted master's counter reads 0.
- R6: In aging mode, in the cycle after a grant, every master that was not granted has a counter one higher than before.
- R7: Age counters saturate at 2^PRIO_W-1 (7 by default) and do not wrap to 0.
- R8: When `req_i` is 0, `gnt_o` is 0 and no counter changes.
- R9: After reset, the counters of masters 0, 1, 2 and 3 hold 3, 2, 1 and 0.
- R10: In static mode the counters keep their values, whatever the requests and grants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; counters update on the rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | Policy select: 0 static, 1 aging |
| req_i | input | 4 | Request line per master, bit n for master n |
| gnt_o | output | 4 | Grant per master, at most one bit set |

## Verification
The hardest condition to reach from the ports is a tie at the saturation value. The age counters cannot be seen directly, so the bench steers them through the grant sequence alone. It keeps master 0 as the only requester for more than eight aging cycles, which drives the other three counters up to the ceiling and holds them there. It then releases master 0 and lets the other three compete. The order of the following grants shows the saturation and the lowest-index tie-break. A bench model tracks every counter, and each grant is compared with it. Scenarios that mix static and idle cycles between aging cycles confirm that those cycles leave the counters untouched.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic {
        POL_STATIC = 1'b0,
        POL_AGING  = 1'b1
    } policy_e;
endpackage

// File: rtl/arb_static_pick.sv
module arb_static_pick #(
    parameter int N_MST = 4
) (
    input  logic [N_MST-1:0] req_i,
    output logic [N_MST-1:0] gnt_o
);
    always_comb begin
        logic taken;
        taken = 1'b0;
        gnt_o = '0;
        for (int i = 0; i < N_MST; i++) begin
            if (req_i[i] && !taken) begin
                gnt_o[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end

    // Lowest requester always wins in this selector
    always_comb begin
        if (req_i[0]) assert_low_index_wins_R2: assert (gnt_o[0]);
    end
endmodule

// File: rtl/arb_age_pick.sv
module arb_age_pick #(
    parameter int N_MST  = 4,
    parameter int PRIO_W = 3
) (
    input  logic [N_MST-1:0]        req_i,
    input  logic [N_MST*PRIO_W-1:0] age_i,
    output logic [N_MST-1:0]        gnt_o
);
    always_comb begin
        logic              taken;
        logic [PRIO_W-1:0] best;
        int                idx;
        taken = 1'b0;
        best  = '0;
        idx   = 0;
        gnt_o = '0;
        for (int i = 0; i < N_MST; i++) begin
            // strict compare keeps the lowest index on ties (R4)
            if (req_i[i] && (!taken || age_i[i*PRIO_W +: PRIO_W] > best)) begin
                taken = 1'b1;
                best  = age_i[i*PRIO_W +: PRIO_W];
                idx   = i;
            end
        end
        if (taken) gnt_o[idx] = 1'b1;
    end
endmodule

// File: rtl/arb_age_bank.sv
module arb_age_bank #(
    parameter int N_MST  = 4,
    parameter int PRIO_W = 3
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    upd_i,
    input  logic [N_MST-1:0]        gnt_i,
    output logic [N_MST*PRIO_W-1:0] age_o
);
    localparam logic [PRIO_W-1:0] AGE_MAX = {PRIO_W{1'b1}};

    typedef struct packed {
        logic [N_MST-1:0][PRIO_W-1:0] age;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (upd_i) begin
            for (int i = 0; i < N_MST; i++) begin
                if (gnt_i[i])
                    st_d.age[i] = '0;
                else if (st_q.age[i] != AGE_MAX)
                    st_d.age[i] = st_q.age[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < N_MST; i++)
                st_q.age[i] <= PRIO_W'(N_MST - 1 - i);
        end else begin
            st_q <= st_d;
        end
    end

    assign age_o = st_q.age;

    generate
        for (genvar g = 0; g < N_MST; g++) begin : g_chk
            assert_winner_cleared_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (upd_i && gnt_i[g]) |=> (st_q.age[g] == '0));
            assert_loser_ages_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (upd_i && !gnt_i[g] && st_q.age[g] != AGE_MAX) |=>
                (st_q.age[g] == $past(st_q.age[g]) + 1'b1));
            assert_no_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (upd_i && !gnt_i[g] && st_q.age[g] == AGE_MAX) |=> (st_q.age[g] == AGE_MAX));
        end
    endgenerate

    assert_hold_when_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !upd_i |=> $stable(st_q));
endmodule

// File: rtl/dual_policy_arbiter.sv
module dual_policy_arbiter #(
    parameter int N_MST  = 4,
    parameter int PRIO_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             mode_i,
    input  logic [N_MST-1:0] req_i,
    output logic [N_MST-1:0] gnt_o
);
    import arb_pkg::*;

    logic [N_MST-1:0]        gnt_static, gnt_age;
    logic [N_MST*PRIO_W-1:0] age;
    logic                    upd;
    policy_e                 pol;

    assign pol = policy_e'(mode_i);

    arb_static_pick #(.N_MST(N_MST)) static_i (
        .req_i (req_i),
        .gnt_o (gnt_static)
    );

    arb_age_pick #(.N_MST(N_MST), .PRIO_W(PRIO_W)) age_pick_i (
        .req_i (req_i),
        .age_i (age),
        .gnt_o (gnt_age)
    );

    // counters move only on aging-mode cycles that grant (R8, R10)
    assign upd = (pol == POL_AGING) && (|req_i);

    arb_age_bank #(.N_MST(N_MST), .PRIO_W(PRIO_W)) bank_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .upd_i  (upd),
        .gnt_i  (gnt_age),
        .age_o  (age)
    );

    assign gnt_o = (pol == POL_AGING) ? gnt_age : gnt_static;

    assert_single_grant_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(gnt_o));
    assert_grant_needs_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gnt_o & ~req_i) == '0);
    assert_someone_served_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i != '0) |-> ($countones(gnt_o) == 1));
    assert_static_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mode_i) |=> $stable(age));
endmodule

// File: tb/dual_policy_arbiter_tb.sv
module dual_policy_arbiter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode;
    logic [3:0] req;
    logic [3:0] gnt;

    int n_checks = 0;
    int n_errors = 0;
    int mp[4];

    always #4 clk = ~clk;

    dual_policy_arbiter dut_i (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .mode_i (mode),
        .req_i  (req),
        .gnt_o  (gnt)
    );

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: gnt actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] model_age(logic [3:0] r);
        logic [3:0] g = '0;
        int best = -1;
        int idx = 0;
        for (int i = 0; i < 4; i++)
            if (r[i] && mp[i] > best) begin best = mp[i]; idx = i; end
        if (best >= 0) g[idx] = 1'b1;
        return g;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req = '0; mode = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mp[0] = 3; mp[1] = 2; mp[2] = 1; mp[3] = 0;   // R9 reset ages
    endtask

    // one cycle: drive, check combinational grant, advance model
    task automatic step(logic m, logic [3:0] r, string tag);
        logic [3:0] exp;
        @(negedge clk);
        mode = m; req = r;
        #1;
        exp = m ? model_age(r) : (r & (~r + 4'd1));
        check(tag, gnt, exp);
        n_checks++;
        if ($countones(gnt) > 1) begin
            n_errors++;
            $display("FAIL R1: gnt actual=%b expected=at most one bit", gnt);
        end
        if (m && r != 0) begin
            for (int i = 0; i < 4; i++)
                mp[i] = exp[i] ? 0 : (mp[i] < 7 ? mp[i] + 1 : 7);  // R5 R6 R7
        end
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        check("R8 reset idle", gnt, 4'b0000);
        step(1'b1, 4'b0110, "R9 first aging pick");   // ages 2 vs 1 -> m1
        check("R9 literal", gnt, 4'b0010);
    endtask

    task automatic t_static();
        do_reset();
        step(1'b0, 4'b1111, "R2 all");
        check("R2 m0 wins", gnt, 4'b0001);
        step(1'b0, 4'b1110, "R2 no m0");
        step(1'b0, 4'b1100, "R2 upper pair");
        step(1'b0, 4'b1000, "R2 m3 only");
        step(1'b0, 4'b1010, "R2 m1 m3");
        step(1'b0, 4'b0000, "R8 static idle");
    endtask

    task automatic t_rotate();
        do_reset();
        for (int k = 0; k < 8; k++) step(1'b1, 4'b1111, "R3 R5 R6 rotation");
        step(1'b1, 4'b1001, "R3 subset");
        step(1'b1, 4'b0101, "R3 subset2");
    endtask

    task automatic t_saturate();
        do_reset();
        for (int k = 0; k < 10; k++) step(1'b1, 4'b0001, "R7 hog m0");
        step(1'b1, 4'b1110, "R4 R7 tie at max");
        check("R4 literal m1", gnt, 4'b0010);
        step(1'b1, 4'b1110, "R4 second");
        check("R4 literal m2", gnt, 4'b0100);
        step(1'b1, 4'b1111, "R7 after sat");
    endtask

    task automatic t_idle();
        do_reset();
        step(1'b1, 4'b1111, "R3 pre idle");
        step(1'b1, 4'b0011, "R3 pre idle2");
        for (int k = 0; k < 5; k++) step(1'b1, 4'b0000, "R8 idle no grant");
        step(1'b1, 4'b1111, "R8 ages held");
        step(1'b1, 4'b1111, "R8 ages held2");
    endtask

    task automatic t_freeze();
        do_reset();
        step(1'b1, 4'b1111, "R3 before static");
        for (int k = 0; k < 6; k++) step(1'b0, 4'b1011, "R10 static traffic");
        step(1'b1, 4'b1111, "R10 ages kept");
        step(1'b1, 4'b1111, "R10 ages kept2");
        step(1'b1, 4'b1111, "R10 ages kept3");
    endtask

    initial begin
        rst_n = 1'b0; mode = 1'b0; req = '0;
        t_reset();
        t_static();
        t_rotate();
        t_saturate();
        t_idle();
        t_freeze();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule